// File: doc/BRIEF.md
# Magnitude Threshold Monitor with Persistence Count

This block watches a stream of ADC conversion results and decides when the signal has been above a programmable magnitude threshold often enough to warrant an interrupt. Every result that arrives with its valid strobe is reduced to an absolute value. The coding of that value depends on a mode input, which selects plain unsigned samples or two's complement samples. The absolute value is compared with a stored threshold. Each reading above the threshold adds to a persistence count. When the count reaches a stored limit, a one-cycle interrupt pulse is raised and the count starts again from zero.

A configuration input decides what a reading at or below the threshold does to the count. It either takes one off the count, stopping at zero, or clears the count at once. Because of this choice the monitor can ignore isolated spikes, ride through brief dips, or demand an unbroken run of high readings. The threshold and the limit are held in registers inside the block. They are loaded together by a load strobe and come out of reset with their default values.

Top module: `mag_threshold_monitor`

## Requirements
- R1: After reset the stored threshold is 0x0000, the stored limit is 0x01, persistCount is 0 and trip is low.
- R2: With twosCompMode = 0 the sample is unsigned, and it counts as above when it is strictly greater than all 16 threshold bits.
- R3: With twosCompMode = 1 the magnitude is the absolute value of the signed sample, and it is compared only with threshold bits 14..0 (bit 15 is ignored).
- R4: With twosCompMode = 1 the most negative code 0x8000 has magnitude 0x7FFF.
- R5: A magnitude exactly equal to the effective threshold is not above it.
- R6: A valid above-threshold reading raises persistCount by one. If the raised value would be greater than or equal to the limit, then one cycle after that sample trip is high for one cycle and persistCount is 0.
- R7: With belowClears = 1, a valid reading that is not above the threshold sets persistCount to 0 one cycle later.
- R8: With belowClears = 0, a valid reading that is not above the threshold lowers persistCount by one. The count never goes below 0.
- R9: In a cycle with sampleValid low, persistCount keeps its value and trip is low in the next cycle.
- R10: A cycle with cfgLoad high stores cfgThreshold and cfgLimit. The new values govern samples from the next cycle on, and persistCount is not changed by the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Store cfgThreshold and cfgLimit |
| cfgThreshold | input | 16 | Threshold value to store |
| cfgLimit | input | 8 | Persistence limit to store |
| twosCompMode | input | 1 | 0 = unsigned samples, 1 = two's complement samples |
| belowClears | input | 1 | 0 = low reading decrements count, 1 = low reading clears count |
| sampleValid | input | 1 | Conversion result strobe |
| sampleData | input | 16 | Conversion result |
| trip | output | 1 | One-cycle comparator interrupt pulse |
| persistCount | output | 8 | Current persistence count |

## Verification
Every result is registered exactly once. A sample presented before a rising edge shows its effect on persistCount and trip right after that edge, so both are due one cycle after the stimulus. A load of the configuration likewise takes effect for the sample in the cycle after the load. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. It first advances its reference model by the same single step, so every comparison lands in the cycle where the result is due. Stimulus is random with a fixed seed, mixed with directed cases for the equal-to-threshold value, 0x8000, the ignored threshold bit 15, and the floor at zero.

// File: rtl/mag_thr_pkg.sv
package mag_thr_pkg;

  // Strobes issued by the control to the datapath counter, at most one per cycle
  typedef struct packed {
    logic inc;   // add one to the persistence count
    logic dec;   // subtract one from the persistence count
    logic clr;   // clear the count without an interrupt
    logic fire;  // clear the count and pulse the interrupt
  } cntCmd_t;

endpackage

// File: rtl/mag_thr_control.sv
module mag_thr_control
  import mag_thr_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic               sampleValid,
  input  logic               aboveThr,
  input  logic               belowClears,
  input  logic [LIMIT_W-1:0] curCount,
  input  logic [LIMIT_W-1:0] curLimit,
  output cntCmd_t            cmd
);

  localparam int CW = LIMIT_W + 1;

  logic [CW-1:0] bumped;

  assign bumped = {1'b0, curCount} + {{LIMIT_W{1'b0}}, 1'b1};

  always_comb begin
    cmd = '0;
    if (sampleValid) begin
      if (aboveThr) begin
        if (bumped >= {1'b0, curLimit}) cmd.fire = 1'b1;
        else                            cmd.inc  = 1'b1;
      end else if (belowClears) begin
        cmd.clr = 1'b1;
      end else if (curCount != '0) begin
        cmd.dec = 1'b1;
      end
    end
  end

  // R6: the counter never receives two strobes in one cycle
  always_comb begin
    assert_cmd_onehot_R6: assert ($onehot0(cmd));
  end

endmodule

// File: rtl/mag_thr_datapath.sv
module mag_thr_datapath
  import mag_thr_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                LIMIT_W     = 8,
  parameter logic [DATA_W-1:0] THR_RESET   = '0,
  parameter logic [LIMIT_W-1:0] LIMIT_RESET = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [DATA_W-1:0]  cfgThreshold,
  input  logic [LIMIT_W-1:0] cfgLimit,
  input  logic               twosCompMode,
  input  logic               belowClears,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleData,
  input  cntCmd_t            cmd,
  output logic               aboveThr,
  output logic [LIMIT_W-1:0] curCount,
  output logic [LIMIT_W-1:0] curLimit,
  output logic               tripPulse
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_MAX  = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] thrReg;
  logic [DATA_W-1:0] negated;
  logic [DATA_W-1:0] magnitude;
  logic [DATA_W-1:0] thrEff;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrReg   <= THR_RESET;
      curLimit <= LIMIT_RESET;
    end else if (cfgLoad) begin
      thrReg   <= cfgThreshold;
      curLimit <= cfgLimit;
    end
  end

  // magnitude and effective threshold follow the coding mode
  assign negated = ~sampleData + {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (twosCompMode) begin
      if (sampleData == MOST_NEG)   magnitude = POS_MAX;
      else if (sampleData[DATA_W-1]) magnitude = negated;
      else                          magnitude = sampleData;
      thrEff = {1'b0, thrReg[DATA_W-2:0]};
    end else begin
      magnitude = sampleData;
      thrEff    = thrReg;
    end
  end

  assign aboveThr = magnitude > thrEff;

  // persistence counter, steered by the control strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount  <= '0;
      tripPulse <= 1'b0;
    end else begin
      tripPulse <= cmd.fire;
      if (cmd.fire || cmd.clr) curCount <= '0;
      else if (cmd.inc)        curCount <= curCount + 1'b1;
      else if (cmd.dec)        curCount <= curCount - 1'b1;
    end
  end

  // R4: a two's complement magnitude never exceeds the largest positive code
  always_comb begin
    if (twosCompMode) assert_tc_mag_range_R4: assert (magnitude <= POS_MAX);
  end

  // R8: no decrement is requested at a count of zero
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> curCount != '0);

  // R9: an idle cycle leaves the count alone and raises no interrupt
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(curCount) && !tripPulse);

  // R7: a low reading in clear mode empties the count
  assert_low_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && !aboveThr && belowClears |=> curCount == '0);

  // R6: an interrupt pulse always comes with an empty count
  assert_trip_rearm_R6: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |-> curCount == '0);

  // R10: loading the configuration never disturbs the count on its own
  assert_load_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad && !sampleValid |=> $stable(curCount));

endmodule

// File: rtl/mag_threshold_monitor.sv
module mag_threshold_monitor
  import mag_thr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [DATA_W-1:0]  cfgThreshold,
  input  logic [LIMIT_W-1:0] cfgLimit,
  input  logic               twosCompMode,
  input  logic               belowClears,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleData,
  output logic               trip,
  output logic [LIMIT_W-1:0] persistCount
);

  cntCmd_t            cmd;
  logic               aboveThr;
  logic [LIMIT_W-1:0] curLimit;

  mag_thr_datapath #(
    .DATA_W      (DATA_W),
    .LIMIT_W     (LIMIT_W),
    .THR_RESET   ('0),
    .LIMIT_RESET (LIMIT_W'(1))
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLoad      (cfgLoad),
    .cfgThreshold (cfgThreshold),
    .cfgLimit     (cfgLimit),
    .twosCompMode (twosCompMode),
    .belowClears  (belowClears),
    .sampleValid  (sampleValid),
    .sampleData   (sampleData),
    .cmd          (cmd),
    .aboveThr     (aboveThr),
    .curCount     (persistCount),
    .curLimit     (curLimit),
    .tripPulse    (trip)
  );

  mag_thr_control #(
    .LIMIT_W (LIMIT_W)
  ) u_control (
    .sampleValid (sampleValid),
    .aboveThr    (aboveThr),
    .belowClears (belowClears),
    .curCount    (persistCount),
    .curLimit    (curLimit),
    .cmd         (cmd)
  );

endmodule

// File: tb/mag_threshold_monitor_tb.sv
module mag_threshold_monitor_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [15:0] cfgThreshold = '0;
  logic [7:0]  cfgLimit = '0;
  logic        twosCompMode = 1'b0;
  logic        belowClears = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic        trip;
  logic [7:0]  persistCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] expThr = 16'h0000;
  logic [7:0]  expLim = 8'h01;
  logic [7:0]  expCount = 8'h00;
  logic        expTrip = 1'b0;

  always #5 clk = ~clk;

  mag_threshold_monitor u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .cfgLoad      (cfgLoad),
    .cfgThreshold (cfgThreshold),
    .cfgLimit     (cfgLimit),
    .twosCompMode (twosCompMode),
    .belowClears  (belowClears),
    .sampleValid  (sampleValid),
    .sampleData   (sampleData),
    .trip         (trip),
    .persistCount (persistCount)
  );

  function automatic logic [15:0] refMag(input logic [15:0] d, input logic tc);
    if (!tc)            return d;
    if (d == 16'h8000)  return 16'h7FFF;
    if (d[15])          return 16'(-d);
    return d;
  endfunction

  function automatic logic refAbove(input logic [15:0] d, input logic tc, input logic [15:0] thr);
    logic [15:0] eff;
    eff = tc ? {1'b0, thr[14:0]} : thr;
    return refMag(d, tc) > eff;
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareOutputs(input string tag);
    check(persistCount == expCount, tag, "persistCount", persistCount, expCount);
    check(trip == expTrip, tag, "trip", trip, expTrip);
  endtask

  // drive one cycle of sample inputs at a falling edge, check at the next
  task automatic step(input logic v, input logic [15:0] d, input logic tc,
                      input logic clr, input string tagIn);
    string tag;
    logic a;
    sampleValid  = v;
    sampleData   = d;
    twosCompMode = tc;
    belowClears  = clr;
    a = refAbove(d, tc, expThr);
    expTrip = 1'b0;
    if (!v) tag = "R9";
    else if (a) begin
      tag = "R6";
      if ({1'b0, expCount} + 9'd1 >= {1'b0, expLim}) begin
        expTrip = 1'b1;
        expCount = '0;
      end else expCount = expCount + 8'd1;
    end else if (clr) begin
      tag = "R7";
      expCount = '0;
    end else begin
      tag = "R8";
      if (expCount != 0) expCount = expCount - 8'd1;
    end
    if (tagIn != "") tag = tagIn;
    @(negedge clk);
    sampleValid = 1'b0;
    compareOutputs(tag);
  endtask

  task automatic load(input logic [15:0] thr, input logic [7:0] lim);
    cfgLoad      = 1'b1;
    cfgThreshold = thr;
    cfgLimit     = lim;
    expThr       = thr;
    expLim       = lim;
    expTrip      = 1'b0;
    @(negedge clk);
    cfgLoad = 1'b0;
    compareOutputs("R10");
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    compareOutputs("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareOutputs("R1");

    // R1: default threshold 0 and limit 1 -> one reading of 1 trips at once
    step(1'b1, 16'h0001, 1'b0, 1'b0, "R1");
    // R5: reading equal to threshold 0 is not above
    step(1'b1, 16'h0000, 1'b0, 1'b0, "R5");

    // R2: unsigned, full 16 bits, limit 3
    load(16'h9000, 8'd3);
    step(1'b1, 16'h9001, 1'b0, 1'b0, "R2");
    step(1'b1, 16'hFFFF, 1'b0, 1'b0, "R2");
    step(1'b1, 16'h9000, 1'b0, 1'b0, "R5");
    step(1'b1, 16'h8FFF, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0000, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0000, 1'b0, 1'b0, "R8");
    step(1'b0, 16'hFFFF, 1'b0, 1'b0, "R9");

    // R3: bit 15 of threshold ignored in two's complement mode
    load(16'h8010, 8'd2);
    step(1'b1, 16'hFFEF, 1'b0, 1'b0, "R2");
    step(1'b1, 16'hFFEF, 1'b1, 1'b0, "R3");
    step(1'b1, 16'h0011, 1'b1, 1'b0, "R3");
    step(1'b1, 16'hFFF0, 1'b1, 1'b1, "R5");
    step(1'b1, 16'hFFEF, 1'b1, 1'b0, "R3");

    // R4: most negative code saturates to 0x7FFF
    load(16'h7FFE, 8'd1);
    step(1'b1, 16'h8000, 1'b1, 1'b0, "R4");
    load(16'h7FFF, 8'd1);
    step(1'b1, 16'h8000, 1'b1, 1'b0, "R4");
    step(1'b1, 16'h8001, 1'b1, 1'b0, "R4");

    // R7 vs R8 responses to a low reading
    load(16'h0100, 8'd5);
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h0010, 1'b0, 1'b0, "R8");
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h0010, 1'b0, 1'b1, "R7");
    // R10: a load leaves the count, new limit applies next sample
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R6");
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R6");
    load(16'h0100, 8'd3);
    step(1'b1, 16'h0200, 1'b0, 1'b0, "R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      if ((i % 97) == 0) begin
        logic [15:0] t;
        t = 16'($urandom_range(16'hA000, 16'h4000));
        if ($urandom_range(1, 0) == 1) t[15] = ~t[15];
        load(t, 8'($urandom_range(6, 0)));
      end
      d = 16'($urandom);
      step(($urandom_range(3, 0) != 0), d, 1'($urandom), 1'($urandom), "");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule